// File: doc/BRIEF.md
# Byte-wide boot loader sequencer

This block fills the on-chip program RAM from an external boot memory that is eight bits wide. It starts in two ways. After reset it starts by itself when the memory-map pin selects the booted map. Software can also start it by setting a force bit in its control register. Each load reads a fixed number of program words from the start of one of eight 8K-byte pages. Each word takes three bytes, the most significant byte first. The packed 24-bit word is written to the internal RAM, and the word index is the RAM address.

The boot address is 16 bits wide. The low 14 bits go out on the address bus. The top two bits go out on the two most significant data-bus lines. The page number is therefore the top three bits of the boot address. Boot select and read are both active low, and they stay low while a byte is being fetched. The wait-state setting stretches every byte access. While a load runs, the core is held. Completion is then flagged.

RAM writes leave through a valid/ready stream. A word stays presented, unchanged, until the RAM accepts it. The boot bus stays quiet while the sequencer waits. When the host-port boot path is selected, this sequencer starts nothing.

Top module: `boot_loader_seq`

## Requirements
- R1: Reset sets the control register to page 0, wait count 7 and force bit clear. During reset, boot select and read stay high and the write stream is idle.
- R2: After reset, a load from page 0 starts by itself when map_sel=0 and boot_mode=0. When map_sel=1, no load starts and the core is not held.
- R3: The host-port path is selected when boot_mode=1 and map_sel=0. While it is selected, no load starts, the strobes stay high and a pending force bit stays set.
- R4: Writing the control register with the force bit set starts a load from the written page. The force bit reads back 1 until the load starts and clears when it starts.
- R5: The byte with offset k is read at boot address {page[2:0], k[12:0]}. Bits 15:14 of that address appear on boot_hi and bits 13:0 appear on boot_addr. Offsets run from 0 to 3*WORDS-1 in increasing order.
- R6: Each byte access holds boot select and read low together for (wait+1) cycles. The byte is sampled on the last of those cycles, so each word costs 3*(wait+1) strobe cycles.
- R7: Word w is {byte 3w, byte 3w+1, byte 3w+2}, with the first byte in bits 23:16. It is presented with ram_wr_addr = w, for w from 0 to WORDS-1.
- R8: While ram_wr_valid is high and ram_wr_ready is low, the address and data stay stable. No boot strobe is asserted while a word is presented.
- R9: core_hold is high from the start of a load until the last word is accepted. In the next cycle core_hold is low and boot_done is high. boot_done clears when a new load starts.
- R10: Page and wait count are captured when a load starts. Register writes made during a load do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_sel | input | 1 | Memory-map select pin; 0 selects the booted map |
| boot_mode | input | 1 | Boot-source select; 1 selects the host port when map_sel=0 |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_page | input | 3 | Page number to write |
| ctl_wait | input | 3 | Wait-state count to write |
| ctl_force | input | 1 | Force-boot bit to write |
| force_pending | output | 1 | Force bit read-back |
| boot_sel_n | output | 1 | Boot memory select, active low |
| boot_rd_n | output | 1 | Boot memory read strobe, active low |
| boot_addr | output | 14 | Boot address bits 13:0 |
| boot_hi | output | 2 | Boot address bits 15:14, driven on the data-bus MSBs |
| boot_byte | input | 8 | Byte from boot memory (data lines 15:8) |
| ram_wr_valid | output | 1 | Packed word available |
| ram_wr_ready | input | 1 | RAM accepts the word |
| ram_wr_addr | output | $clog2(WORDS) | RAM word address |
| ram_wr_data | output | 24 | Packed program word |
| core_hold | output | 1 | Holds the core while loading |
| boot_done | output | 1 | Last load finished |

## Verification
The boot memory model returns a byte computed from the full 16-bit boot address. That byte mixes the page bits with the offset bits, so a wrong page, a wrong offset or a reordered byte each gives a different word. Every pairing of the eight pages with the eight wait counts is loaded. Half of those loads run with a RAM that accepts one cycle in three; this separates the stall behaviour from the strobe-length count. Further loads cover the automatic start after reset at the default wait count, a register write made in the middle of a load, and a force request held back by the host-port select and released when the select drops.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/boot_ctl_reg.sv
module boot_ctl_reg #(
  parameter int PAGE_BITS = 3,
  parameter int WAIT_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [PAGE_BITS-1:0] wr_page,
  input  logic [WAIT_BITS-1:0] wr_wait,
  input  logic                 wr_force,
  input  logic                 force_clr,
  output logic [PAGE_BITS-1:0] page,
  output logic [WAIT_BITS-1:0] wait_n,
  output logic                 force_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page    <= '0;
      wait_n  <= '1;
      force_q <= 1'b0;
    end else begin
      if (wr) begin
        page   <= wr_page;
        wait_n <= wr_wait;
      end
      if (wr && wr_force) force_q <= 1'b1;
      else if (force_clr) force_q <= 1'b0;
    end
  end
endmodule

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
  parameter int WAIT_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [WAIT_BITS-1:0] load_val,
  input  logic                 run,
  output logic                 expire
);
  logic [WAIT_BITS-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (run && cnt != '0)    cnt <= cnt - WAIT_BITS'(1);
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/boot_addr_gen.sv
module boot_addr_gen #(
  parameter int WORDS   = 2048,
  parameter int PAGE_AW = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      byte_step,
  input  logic                      word_step,
  output logic [PAGE_AW-1:0]        byte_ofs,
  output logic [$clog2(WORDS)-1:0]  word_idx,
  output logic                      third_byte,
  output logic                      last_word
);
  localparam int WIDX_W = $clog2(WORDS);

  logic [1:0] byte_pos;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      byte_ofs <= '0;
      byte_pos <= '0;
      word_idx <= '0;
    end else begin
      if (byte_step) begin
        byte_ofs <= byte_ofs + PAGE_AW'(1);
        byte_pos <= third_byte ? 2'd0 : byte_pos + 2'd1;
      end
      if (word_step) word_idx <= word_idx + WIDX_W'(1);
    end
  end

  assign third_byte = (byte_pos == 2'd2);
  assign last_word  = (word_idx == WIDX_W'(WORDS - 1));
endmodule

// File: rtl/boot_word_packer.sv
module boot_word_packer #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)       word <= '0;
    else if (capture) word <= {word[WORD_W-BYTE_W-1:0], byte_in};
  end
endmodule

// File: rtl/boot_loader_seq.sv
module boot_loader_seq
  import boot_seq_pkg::*;
#(
  parameter int WORDS     = 2048,
  parameter int PAGE_BITS = 3,
  parameter int WAIT_BITS = 3,
  parameter int PAGE_AW   = 13,
  parameter int ADDR_W    = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      map_sel,
  input  logic                      boot_mode,
  input  logic                      ctl_wr,
  input  logic [PAGE_BITS-1:0]      ctl_page,
  input  logic [WAIT_BITS-1:0]      ctl_wait,
  input  logic                      ctl_force,
  output logic                      force_pending,
  output logic                      boot_sel_n,
  output logic                      boot_rd_n,
  output logic [ADDR_W-1:0]         boot_addr,
  output logic [PAGE_BITS+PAGE_AW-ADDR_W-1:0] boot_hi,
  input  logic [7:0]                boot_byte,
  output logic                      ram_wr_valid,
  input  logic                      ram_wr_ready,
  output logic [$clog2(WORDS)-1:0]  ram_wr_addr,
  output logic [23:0]               ram_wr_data,
  output logic                      core_hold,
  output logic                      boot_done
);
  localparam int FULL_W = PAGE_BITS + PAGE_AW;

  seq_state_t state;
  logic [PAGE_BITS-1:0] reg_page, snap_page;
  logic [WAIT_BITS-1:0] reg_wait, snap_wait;
  logic force_q, auto_pend, host_sel, auto_ok;
  logic start, capture, handshake, expire, third_byte, last_word;
  logic timer_load;
  logic [PAGE_AW-1:0] byte_ofs;
  logic [FULL_W-1:0]  full_addr;

  assign host_sel = boot_mode & ~map_sel;
  assign auto_ok  = ~boot_mode & ~map_sel;

  boot_ctl_reg #(.PAGE_BITS(PAGE_BITS), .WAIT_BITS(WAIT_BITS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wr_page(ctl_page),
    .wr_wait(ctl_wait), .wr_force(ctl_force), .force_clr(start),
    .page(reg_page), .wait_n(reg_wait), .force_q(force_q)
  );

  assign start = (state == ST_IDLE) &&
                 ((auto_pend && auto_ok) || (force_q && !host_sel));
  assign capture   = (state == ST_READ) && expire;
  assign handshake = (state == ST_WRITE) && ram_wr_ready;
  assign timer_load = start || (capture && !third_byte) || (handshake && !last_word);

  boot_wait_timer #(.WAIT_BITS(WAIT_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load),
    .load_val(start ? reg_wait : snap_wait),
    .run(state == ST_READ), .expire(expire)
  );

  boot_addr_gen #(.WORDS(WORDS), .PAGE_AW(PAGE_AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .clear(start), .byte_step(capture),
    .word_step(handshake), .byte_ofs(byte_ofs), .word_idx(ram_wr_addr),
    .third_byte(third_byte), .last_word(last_word)
  );

  boot_word_packer #(.BYTE_W(8), .WORD_W(24)) u_pack (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .byte_in(boot_byte), .word(ram_wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      auto_pend <= 1'b1;
      boot_done <= 1'b0;
      snap_page <= '0;
      snap_wait <= '1;
    end else begin
      if (state == ST_IDLE) auto_pend <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_READ;
          boot_done <= 1'b0;
          snap_page <= reg_page;
          snap_wait <= reg_wait;
        end
        ST_READ: if (capture && third_byte) state <= ST_WRITE;
        ST_WRITE: if (handshake) begin
          if (last_word) begin
            state     <= ST_IDLE;
            boot_done <= 1'b1;
          end else begin
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign full_addr     = {snap_page, byte_ofs};
  assign boot_addr     = full_addr[ADDR_W-1:0];
  assign boot_hi       = full_addr[FULL_W-1:ADDR_W];
  assign boot_sel_n    = (state != ST_READ);
  assign boot_rd_n     = (state != ST_READ);
  assign ram_wr_valid  = (state == ST_WRITE);
  assign force_pending = force_q;
  assign core_hold     = (state != ST_IDLE) || (auto_pend && auto_ok);
endmodule

// File: rtl/boot_loader_seq_chk.sv
module boot_loader_seq_chk #(
  parameter int WORDS = 2048
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     boot_sel_n,
  input logic                     boot_rd_n,
  input logic                     ram_wr_valid,
  input logic                     ram_wr_ready,
  input logic [$clog2(WORDS)-1:0] ram_wr_addr,
  input logic [23:0]              ram_wr_data,
  input logic                     core_hold,
  input logic                     boot_done,
  input logic                     force_pending,
  input logic                     host_sel
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_valid && !ram_wr_ready |=>
      ram_wr_valid && $stable(ram_wr_data) && $stable(ram_wr_addr));

  // R8
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_valid |-> boot_sel_n && boot_rd_n);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !core_hold);

  // R4
  force_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_pending && !core_hold && !host_sel |=> core_hold);

  // R3
  host_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && !core_hold |=> boot_sel_n);
endmodule

bind boot_loader_seq boot_loader_seq_chk #(.WORDS(WORDS)) u_boot_chk (
  .clk(clk), .rst_n(rst_n), .boot_sel_n(boot_sel_n), .boot_rd_n(boot_rd_n),
  .ram_wr_valid(ram_wr_valid), .ram_wr_ready(ram_wr_ready),
  .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
  .core_hold(core_hold), .boot_done(boot_done),
  .force_pending(force_pending), .host_sel(host_sel)
);

// File: tb/test_boot_loader_seq.sv
module test_boot_loader_seq;
  localparam int WORDS = 4;
  localparam int AW    = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_sel = 1'b1, boot_mode = 1'b0;
  logic ctl_wr = 1'b0, ctl_force = 1'b0;
  logic [2:0] ctl_page = '0, ctl_wait = '0;
  logic force_pending, boot_sel_n, boot_rd_n, ram_wr_valid, core_hold, boot_done;
  logic ram_wr_ready = 1'b1;
  logic [13:0] boot_addr;
  logic [1:0]  boot_hi;
  logic [7:0]  boot_byte;
  logic [AW-1:0] ram_wr_addr;
  logic [23:0] ram_wr_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  boot_loader_seq #(.WORDS(WORDS)) i_boot_loader_seq (
    .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .boot_mode(boot_mode),
    .ctl_wr(ctl_wr), .ctl_page(ctl_page), .ctl_wait(ctl_wait),
    .ctl_force(ctl_force), .force_pending(force_pending),
    .boot_sel_n(boot_sel_n), .boot_rd_n(boot_rd_n), .boot_addr(boot_addr),
    .boot_hi(boot_hi), .boot_byte(boot_byte), .ram_wr_valid(ram_wr_valid),
    .ram_wr_ready(ram_wr_ready), .ram_wr_addr(ram_wr_addr),
    .ram_wr_data(ram_wr_data), .core_hold(core_hold), .boot_done(boot_done)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd7;
    return m ^ {a[15:13], a[12:8]};
  endfunction

  function automatic logic [15:0] baddr(input int page, input int ofs);
    return {page[2:0], ofs[12:0]};
  endfunction

  assign boot_byte = (!boot_sel_n && !boot_rd_n) ? mem_byte({boot_hi, boot_addr}) : 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Follows one whole load, checking strobes, addresses, words and completion.
  task automatic run_boot(input int page, input int wt, input bit stall, input bit poke);
    int cyc = 0, w = 0, sc = 0, guard = 0;
    bit started = 0, waiting = 0, poked = 0;
    logic [23:0] pd = '0;
    logic [AW-1:0] pa = '0;
    while (w < WORDS && guard < 5000) begin
      @(negedge clk);
      guard++;
      ctl_wr = 1'b0;
      if (!started && (core_hold || !boot_sel_n)) started = 1;
      if (started) begin
        chk(core_hold == 1'b1, "R9 hold during load", 32'(core_hold), 1);
        chk(boot_done == 1'b0, "R9 done cleared", 32'(boot_done), 0);
        chk(force_pending == 1'b0, "R4 force self-clear", 32'(force_pending), 0);
      end
      if (!boot_sel_n) begin
        int idx = 3 * w + cyc / (wt + 1);
        chk(boot_rd_n == 1'b0, "R6 read with select", 32'(boot_rd_n), 0);
        chk({boot_hi, boot_addr} == baddr(page, idx), "R5 boot address",
            32'({boot_hi, boot_addr}), 32'(baddr(page, idx)));
        chk(ram_wr_valid == 1'b0, "R8 no write while reading", 32'(ram_wr_valid), 0);
        cyc++;
        if (poke && !poked && cyc == 1) begin
          // R10: rewrite the register mid-load, no force
          ctl_wr = 1'b1; ctl_page = 3'(page + 3); ctl_wait = 3'(wt + 2); ctl_force = 1'b0;
          poked = 1;
        end
      end
      if (ram_wr_valid) begin
        logic [23:0] ew;
        ew = {mem_byte(baddr(page, 3 * w)), mem_byte(baddr(page, 3 * w + 1)),
              mem_byte(baddr(page, 3 * w + 2))};
        chk(boot_sel_n && boot_rd_n, "R8 bus quiet", 32'({boot_sel_n, boot_rd_n}), 3);
        if (waiting)
          chk(ram_wr_data == pd && ram_wr_addr == pa, "R8 stable under stall",
              32'(ram_wr_data), 32'(pd));
        chk(cyc == 3 * (wt + 1), "R6 strobe cycles per word", 32'(cyc), 32'(3 * (wt + 1)));
        chk(ram_wr_addr == AW'(w), "R7 ram address", 32'(ram_wr_addr), 32'(w));
        chk(ram_wr_data == ew, "R7 packed word", 32'(ram_wr_data), 32'(ew));
        ram_wr_ready = stall ? (sc % 3 == 2) : 1'b1;
        sc++;
        if (ram_wr_ready) begin
          w++; cyc = 0; waiting = 0;
        end else begin
          waiting = 1; pd = ram_wr_data; pa = ram_wr_addr;
        end
      end else begin
        ram_wr_ready = !stall;
      end
    end
    @(negedge clk);
    ctl_wr = 1'b0;
    chk(w == WORDS, "R9 all words written", 32'(w), 32'(WORDS));
    chk(core_hold == 1'b0, "R9 hold released", 32'(core_hold), 0);
    chk(boot_done == 1'b1, "R9 done raised", 32'(boot_done), 1);
    ram_wr_ready = 1'b1;
  endtask

  task automatic do_force(input int page, input int wt);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_page = 3'(page); ctl_wait = 3'(wt); ctl_force = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_force = 1'b0;
    chk(force_pending == 1'b1, "R4 force set", 32'(force_pending), 1);
  endtask

  task automatic do_reset(input logic ms, input logic bm);
    rst_n = 1'b0; map_sel = ms; boot_mode = bm;
    repeat (3) @(negedge clk);
    chk(boot_sel_n && boot_rd_n, "R1 strobes high in reset", 32'({boot_sel_n, boot_rd_n}), 3);
    chk(ram_wr_valid == 1'b0, "R1 stream idle in reset", 32'(ram_wr_valid), 0);
    chk(force_pending == 1'b0, "R1 force clear", 32'(force_pending), 0);
    chk(boot_done == 1'b0, "R1 done clear", 32'(boot_done), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    // R2: no auto load with map_sel=1
    do_reset(1'b1, 1'b0);
    repeat (6) begin
      @(negedge clk);
      chk(boot_sel_n == 1'b1, "R2 no auto load", 32'(boot_sel_n), 1);
      chk(core_hold == 1'b0, "R2 core free", 32'(core_hold), 0);
    end
    // R2 / R1: auto load page 0 with default wait 7
    do_reset(1'b0, 1'b0);
    run_boot(0, 7, 1'b0, 1'b0);

    // Sweep every page against every wait count
    for (int p = 0; p < 8; p++) begin
      for (int wt = 0; wt < 8; wt++) begin
        do_force(p, wt);
        run_boot(p, wt, 1'(p + wt), 1'b0);
      end
    end

    // R10: register write during a load
    do_force(5, 2);
    run_boot(5, 2, 1'b0, 1'b1);

    // R3: host-port boot selected
    @(negedge clk);
    boot_mode = 1'b1; map_sel = 1'b0;
    do_force(6, 1);
    repeat (30) begin
      @(negedge clk);
      chk(boot_sel_n == 1'b1, "R3 no strobe", 32'(boot_sel_n), 1);
      chk(ram_wr_valid == 1'b0, "R3 no write", 32'(ram_wr_valid), 0);
      chk(force_pending == 1'b1, "R3 force kept", 32'(force_pending), 1);
      chk(core_hold == 1'b0, "R3 no hold", 32'(core_hold), 0);
    end
    boot_mode = 1'b0;
    run_boot(6, 1, 1'b1, 1'b0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule